// File: doc/BRIEF.md
# PLL Lock Detector and Holdover Controller

This block sits beside the phase comparator of a clock-cleaning PLL. It watches two clocks: the divided reference and the divided oscillator feedback. A fast sampling clock measures them. Each input first passes through a two-flop synchronizer. The block then finds rising edges and pairs each reference edge with the nearest feedback edge. It counts the sample ticks between the two edges of a pair and compares that count with a programmable tolerance window. Lock is declared once five pairs in a row land inside the window. A single pair outside the window clears lock again.

The block also checks that each clock is present. A clock counts as active only while the gap between its rising edges stays at or below a programmable tick limit. That limit stands in for the minimum frequency of the clock.

A three-state holdover machine uses these results. After reset it waits in the pre-lock state. Once the reference is active and lock is held, it moves to the controlled state. While hold is enabled, the first missing reference cycle moves it to holdover, and there the charge-pump enable drops so the pump output floats. When reference edges return, the machine goes back to pre-lock and the lock count starts from zero.

Top module: `pll_lock_hold_ctl`

## Requirements
- R1: After reset: `lock`=0, `ref_ok`=0, `fb_ok`=0, `pump_en`=1 and `hold_state`=0 (pre-lock).
- R2: `lock` goes to 1 after the fifth consecutive in-window edge pair. An edge pair is in-window when the offset between the two rising edges is at most the window, in sample ticks. The two edges may come in either order.
- R3: An edge pair is out-of-window when its offset exceeds the window. A pair also counts as out-of-window when a second edge of the same clock arrives before the partner edge. One out-of-window pair clears `lock` and the consecutive count.
- R4: `win_sel` codes 0, 1, 2 and 3 set the window to 2, 3, 4 and 5 times `UNIT_TICKS`. The offset equal to the window still counts as in-window.
- R5: `hold_state` encodes pre-lock as 0, controlled as 1 and holdover as 2. It moves from 0 to 1 when `ref_ok` and `lock` are both 1.
- R6: In state 1, with `hold_en`=1, a missing reference moves the machine to state 2, and `pump_en` is 0 while in state 2. The reference is missing once `MISS_GAP` ticks pass with no reference rise.
- R7: In state 1, with `hold_en`=0, a missing reference returns the machine to state 0, and `pump_en` stays 1.
- R8: In state 2, a reference rising edge returns the machine to state 0 and clears the lock count, so `lock` is 0.
- R9: `ref_ok` (`fb_ok`) is 1 only while successive rises of that clock are at most `REF_MAX_GAP` (`FB_MAX_GAP`) ticks apart. It is set on the second such rise and cleared once the gap grows past the limit.
- R10: Both clock inputs are synchronized by two flops. A rise driven before clock edge k affects the outputs at edge k+2, that is, on the third edge counting edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_in | input | 1 | Divided reference clock, asynchronous |
| fb_clk_in | input | 1 | Divided oscillator feedback clock, asynchronous |
| win_sel | input | 2 | Phase window code |
| hold_en | input | 1 | Enables entry into holdover |
| lock | output | 1 | Lock indication |
| ref_ok | output | 1 | Reference clock activity flag |
| fb_ok | output | 1 | Feedback clock activity flag |
| pump_en | output | 1 | Charge pump drive enable, 0 means high impedance |
| hold_state | output | 2 | Holdover machine state |

## Verification
Every result is due exactly three rising edges after an input rise is driven. Two of those edges go through the synchronizer and the third loads the registered outputs. Window timeouts and missing-reference detection then add their own tick counts after the last rise. The bench drives inputs and samples outputs on falling edges. It advances a timestamp-based model on each rising edge, so the expected value and the design output refer to the same edge. Directed checks taken after the third edge pin down that latency around the return from holdover.

// File: rtl/pll_lhc_pkg.sv
`timescale 1ns/1ps
package pll_lhc_pkg;
    typedef enum logic [1:0] {
        ST_PRELOCK   = 2'd0,
        ST_HOLD_CTRL = 2'd1,
        ST_HOLD_OP   = 2'd2
    } hold_st_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_REF  = 2'd1,
        PEND_FB   = 2'd2
    } pend_e;
endpackage

// File: rtl/lhc_sync_edge.sv
`timescale 1ns/1ps
module lhc_sync_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.s2 & ~sync_q.s3;
endmodule

// File: rtl/lhc_phase_win.sv
`timescale 1ns/1ps
module lhc_phase_win
    import pll_lhc_pkg::*;
#(
    parameter int UNIT_TICKS = 2,
    parameter int LOCK_N     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_edge,
    input  logic       fb_edge,
    input  logic [1:0] win_sel,
    input  logic       clr,
    output logic       lock
);
    localparam int WMAX = 5 * UNIT_TICKS;
    localparam int CW   = $clog2(WMAX + 1);
    localparam int LW   = $clog2(LOCK_N + 1);

    typedef struct packed {
        pend_e         pend;
        logic [CW-1:0] cnt;
        logic [LW-1:0] lcnt;
        logic          lock;
    } pw_t;

    pw_t pw_d, pw_q;
    logic hit, miss;
    int   win_i;

    always_comb begin
        pw_d  = pw_q;
        hit   = 1'b0;
        miss  = 1'b0;
        win_i = (int'(win_sel) + 2) * UNIT_TICKS;
        if (ref_edge && fb_edge) begin
            hit       = 1'b1;
            pw_d.pend = PEND_NONE;
        end else if (ref_edge || fb_edge) begin
            if (pw_q.pend == PEND_NONE) begin
                pw_d.pend = ref_edge ? PEND_REF : PEND_FB;
                pw_d.cnt  = CW'(1);
            end else if ((pw_q.pend == PEND_REF && fb_edge) ||
                         (pw_q.pend == PEND_FB && ref_edge)) begin
                if (int'(pw_q.cnt) <= win_i) hit = 1'b1;
                else                         miss = 1'b1;
                pw_d.pend = PEND_NONE;
            end else begin
                miss     = 1'b1;
                pw_d.cnt = CW'(1);
            end
        end else if (pw_q.pend != PEND_NONE) begin
            if (int'(pw_q.cnt) >= win_i) begin
                miss      = 1'b1;
                pw_d.pend = PEND_NONE;
            end else begin
                pw_d.cnt = pw_q.cnt + 1'b1;
            end
        end

        if (clr)
            pw_d.lcnt = '0;
        else if (hit && (int'(pw_q.lcnt) < LOCK_N))
            pw_d.lcnt = pw_q.lcnt + 1'b1;
        else if (miss)
            pw_d.lcnt = '0;
        pw_d.lock = (int'(pw_d.lcnt) >= LOCK_N);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q.pend <= PEND_NONE;
            pw_q.cnt  <= '0;
            pw_q.lcnt <= '0;
            pw_q.lock <= 1'b0;
        end else begin
            pw_q <= pw_d;
        end
    end

    assign lock = pw_q.lock;
endmodule

// File: rtl/lhc_activity.sv
`timescale 1ns/1ps
module lhc_activity #(
    parameter int REF_MAX_GAP = 70,
    parameter int FB_MAX_GAP  = 50,
    parameter int MISS_GAP    = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rise,
    output logic [1:0] ok,
    output logic       ref_miss
);
    localparam int BIG2 = (REF_MAX_GAP > FB_MAX_GAP) ? REF_MAX_GAP : FB_MAX_GAP;
    localparam int GMAX = ((BIG2 > MISS_GAP) ? BIG2 : MISS_GAP) + 1;
    localparam int GW   = $clog2(GMAX + 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic          ok;
    } chan_t;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        localparam int LIM = (c == 0) ? REF_MAX_GAP : FB_MAX_GAP;
        chan_t ch_d, ch_q;

        always_comb begin
            ch_d.ok = (int'(ch_q.gap) < LIM) && (rise[c] || ch_q.ok);
            if (rise[c])                   ch_d.gap = '0;
            else if (int'(ch_q.gap) < GMAX) ch_d.gap = ch_q.gap + 1'b1;
            else                           ch_d.gap = ch_q.gap;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_q.gap <= GW'(GMAX);
                ch_q.ok  <= 1'b0;
            end else begin
                ch_q <= ch_d;
            end
        end

        assign ok[c] = ch_q.ok;

        if (c == 0) begin : g_miss
            assign ref_miss = !rise[0] && (int'(ch_q.gap) == MISS_GAP - 1);
        end
    end
endmodule

// File: rtl/pll_lock_hold_ctl.sv
`timescale 1ns/1ps
module pll_lock_hold_ctl
    import pll_lhc_pkg::*;
#(
    parameter int UNIT_TICKS  = 2,
    parameter int LOCK_N      = 5,
    parameter int REF_MAX_GAP = 70,
    parameter int FB_MAX_GAP  = 50,
    parameter int MISS_GAP    = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_clk_in,
    input  logic       fb_clk_in,
    input  logic [1:0] win_sel,
    input  logic       hold_en,
    output logic       lock,
    output logic       ref_ok,
    output logic       fb_ok,
    output logic       pump_en,
    output logic [1:0] hold_state
);
    typedef struct packed {
        hold_st_e st;
    } top_t;

    top_t       top_d, top_q;
    logic [1:0] rise;
    logic [1:0] act_ok;
    logic       ref_miss;
    logic       clr;

    lhc_sync_edge #(.N(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({fb_clk_in, ref_clk_in}),
        .rise     (rise)
    );

    lhc_phase_win #(.UNIT_TICKS(UNIT_TICKS), .LOCK_N(LOCK_N)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_edge (rise[0]),
        .fb_edge  (rise[1]),
        .win_sel  (win_sel),
        .clr      (clr),
        .lock     (lock)
    );

    lhc_activity #(
        .REF_MAX_GAP (REF_MAX_GAP),
        .FB_MAX_GAP  (FB_MAX_GAP),
        .MISS_GAP    (MISS_GAP)
    ) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .ok       (act_ok),
        .ref_miss (ref_miss)
    );

    always_comb begin
        top_d = top_q;
        clr   = 1'b0;
        case (top_q.st)
            ST_PRELOCK: begin
                if (act_ok[0] && lock) top_d.st = ST_HOLD_CTRL;
            end
            ST_HOLD_CTRL: begin
                if (ref_miss) top_d.st = hold_en ? ST_HOLD_OP : ST_PRELOCK;
            end
            ST_HOLD_OP: begin
                if (rise[0]) begin
                    top_d.st = ST_PRELOCK;
                    clr      = 1'b1;
                end
            end
            default: top_d.st = ST_PRELOCK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q.st <= ST_PRELOCK;
        else        top_q    <= top_d;
    end

    assign ref_ok     = act_ok[0];
    assign fb_ok      = act_ok[1];
    assign pump_en    = (top_q.st != ST_HOLD_OP);
    assign hold_state = top_q.st;
endmodule

// File: rtl/pll_lock_hold_ctl_chk.sv
`timescale 1ns/1ps
module pll_lock_hold_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lock,
    input logic       ref_ok,
    input logic       hold_en,
    input logic [1:0] hold_state
);
    p_state_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_state != 2'd3);

    p_enter_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_state == 2'd1 && $past(hold_state) == 2'd0) |-> ($past(lock) && $past(ref_ok)));

    p_enter_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_state == 2'd2 && $past(hold_state) != 2'd2) |-> ($past(hold_en) && $past(hold_state) == 2'd1));

    p_drop_nohold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_state == 2'd0 && $past(hold_state) == 2'd1) |-> !$past(hold_en));

    p_leave_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_state != 2'd2 && $past(hold_state) == 2'd2) |-> (hold_state == 2'd0 && !lock));

    p_lock_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> ($past(hold_state) != 2'd2));
endmodule

bind pll_lock_hold_ctl pll_lock_hold_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock       (lock),
    .ref_ok     (ref_ok),
    .hold_en    (hold_en),
    .hold_state (hold_state)
);

// File: tb/pll_lock_hold_ctl_tb_top.sv
`timescale 1ns/1ps
module pll_lock_hold_ctl_tb_top;
    localparam int UNIT = 2, LOCKN = 5, RMAX = 70, FMAX = 50, MISS = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0, fb_in = 1'b0, hold_en = 1'b0;
    logic [1:0] win_sel = 2'd0;
    logic       lock, ref_ok, fb_ok, pump_en;
    logic [1:0] hold_state;

    int errors = 0, checks = 0;
    int ph = 0, per = 40, off = 0;
    bit ref_on = 1'b0, fb_on = 1'b0;

    always #2 clk = ~clk;

    pll_lock_hold_ctl #(
        .UNIT_TICKS(UNIT), .LOCK_N(LOCKN), .REF_MAX_GAP(RMAX),
        .FB_MAX_GAP(FMAX), .MISS_GAP(MISS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_in), .fb_clk_in(fb_in),
        .win_sel(win_sel), .hold_en(hold_en), .lock(lock), .ref_ok(ref_ok),
        .fb_ok(fb_ok), .pump_en(pump_en), .hold_state(hold_state)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: timestamps of edges, advanced on each rising clock edge.
    int  cyc, pend, pend_t, lcnt, last_r, last_f, st, nst, win;
    bit  m_lock, m_rok, m_fok, r1, r2, r3, f1, f2, f3;
    bit  re, fe, hit, mis, rmiss, clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; pend = 0; pend_t = 0; lcnt = 0; last_r = -1000; last_f = -1000;
            st = 0; m_lock = 0; m_rok = 0; m_fok = 0;
            r1 = 0; r2 = 0; r3 = 0; f1 = 0; f2 = 0; f3 = 0;
        end else begin
            re = r2 & ~r3; fe = f2 & ~f3;
            r3 = r2; r2 = r1; r1 = ref_in;
            f3 = f2; f2 = f1; f1 = fb_in;
            win = (int'(win_sel) + 2) * UNIT;
            hit = 0; mis = 0;
            if (re && fe) begin
                hit = 1; pend = 0;
            end else if (re || fe) begin
                if (pend == 0) begin
                    pend = re ? 1 : 2; pend_t = cyc;
                end else if ((pend == 1 && fe) || (pend == 2 && re)) begin
                    if (cyc - pend_t <= win) hit = 1; else mis = 1;
                    pend = 0;
                end else begin
                    mis = 1; pend_t = cyc;
                end
            end else if (pend != 0 && cyc - pend_t >= win) begin
                mis = 1; pend = 0;
            end
            rmiss = !re && (cyc - last_r == MISS);
            m_rok = (cyc - last_r <= RMAX) && (re || m_rok);
            m_fok = (cyc - last_f <= FMAX) && (fe || m_fok);
            if (re) last_r = cyc;
            if (fe) last_f = cyc;
            clr = 0; nst = st;
            if (st == 0 && m_lock && (cyc - last_r) >= 0) begin end
            case (st)
                0: if (ok_prev_r && m_lock) nst = 1;
                1: if (rmiss) nst = hold_en ? 2 : 0;
                2: if (re) begin nst = 0; clr = 1; end
                default: nst = 0;
            endcase
            if (clr) lcnt = 0;
            else if (hit) lcnt = (lcnt < LOCKN) ? lcnt + 1 : lcnt;
            else if (mis) lcnt = 0;
            m_lock = (lcnt >= LOCKN);
            st = nst;
            ok_prev_r = m_rok;
            cyc++;
        end
    end
    bit ok_prev_r = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R3/R10 lock", int'(lock), int'(m_lock));
            check("R9 ref_ok", int'(ref_ok), int'(m_rok));
            check("R9 fb_ok", int'(fb_ok), int'(m_fok));
            check("R5/R6/R7/R8 hold_state", int'(hold_state), st);
            check("R6 pump_en", int'(pump_en), int'(st != 2));
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            ref_in = ref_on && ((ph % per) < per / 2);
            fb_in  = fb_on && (((ph - off + 1000 * per) % per) < per / 2);
            ph++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lock", int'(lock), 0);
        check("R1 ref_ok", int'(ref_ok), 0);
        check("R1 fb_ok", int'(fb_ok), 0);
        check("R1 pump_en", int'(pump_en), 1);
        check("R1 hold_state", int'(hold_state), 0);

        ref_on = 1; fb_on = 1; off = 0;
        run(150);
        check("R2 four pairs only", int'(lock), 0);
        run(250);
        check("R2 locked", int'(lock), 1);
        check("R9 ref active", int'(ref_ok), 1);
        check("R9 fb active", int'(fb_ok), 1);
        check("R5 controlled", int'(hold_state), 1);

        off = 4; run(300);
        check("R4 code0 boundary in", int'(lock), 1);
        off = 5; run(200);
        check("R3 code0 out", int'(lock), 0);
        win_sel = 2'd3; off = 10; run(300);
        check("R4 code3 boundary in", int'(lock), 1);
        win_sel = 2'd1; off = 7; run(200);
        check("R4 code1 out", int'(lock), 0);
        off = 6; run(300);
        check("R4 code1 in", int'(lock), 1);
        win_sel = 2'd0; off = -4; run(300);
        check("R2 feedback leads", int'(lock), 1);
        check("R5 still controlled", int'(hold_state), 1);

        hold_en = 0; ref_on = 0; run(100);
        check("R7 back to prelock", int'(hold_state), 0);
        check("R7 pump kept", int'(pump_en), 1);
        check("R9 ref lost", int'(ref_ok), 0);

        ref_on = 1; run(400);
        check("R5 relocked", int'(hold_state), 1);
        hold_en = 1; ref_on = 0; run(100);
        check("R6 holdover", int'(hold_state), 2);
        check("R6 pump off", int'(pump_en), 0);

        ph = ((ph / per) + 1) * per; ref_on = 1;
        run(2);
        check("R10 not before third edge", int'(hold_state), 2);
        run(1);
        check("R8 leave holdover", int'(hold_state), 0);
        check("R8 lock cleared", int'(lock), 0);
        run(400);
        check("R5 controlled again", int'(hold_state), 1);

        fb_on = 0; run(100);
        check("R9 fb lost", int'(fb_ok), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule